// File: doc/BRIEF.md
# Two-Phase Transition-Signalled Latch Pipeline

This block is a linear FIFO of `STAGES` storage stages. Items move through it under a two-phase request/acknowledge handshake, with the data word bundled beside the request. Each stage holds one word. A single XNOR-style controller per stage decides whether the stage is open. The stage is open when its own done flag equals the done flag of the stage after it, which means the stage is empty. When a fresh request edge arrives at an open stage, the stage captures the word and toggles its done flag. That toggle closes the stage. It also acts as the request to the next stage and as the acknowledge to the previous stage.

The design is written as a cycle-evaluated model of the clockless structure. On every clock edge, each stage controller looks at its inputs and may capture one item. Tokens therefore advance at most one stage per cycle. On the producer side, the producer toggles `reqIn` with a valid `dataIn` and waits until `ackOut` equals `reqIn`. On the consumer side, the output fans out to two consumers. The last stage sees a single acknowledge, which is the merge of `ackInA` and `ackInB` through a resettable Muller C-element. Both consumers must therefore toggle before the last stage can take its next item.

Top module: `tpLatchPipeline`

## Requirements
- R1: While `rstN` is low and after its release, `ackOut`, `reqOut` and `dataOut` are 0, and every stage is empty.
- R2: A rising edge and a falling edge of `reqIn` each carry one item. Each accepted item toggles `ackOut` exactly once. Two `ackOut` toggles are never on consecutive cycles.
- R3: Each stage holds at most one item. If the consumers never acknowledge, exactly `STAGES` items are accepted. After that, `ackOut` does not follow a further `reqIn` toggle.
- R4: Every word leaves at `dataOut` exactly once and in the order it entered. It is marked by one `reqOut` toggle and keeps its value unchanged.
- R5: On an empty pipeline, `ackOut` toggles on the first clock edge after a `reqIn` toggle. `reqOut` toggles on the `STAGES`-th edge.
- R6: While `reqOut` differs from the merged acknowledge, `reqOut` and `dataOut` hold their values.
- R7: The merged acknowledge changes only once `ackInA` and `ackInB` both match its new value. A toggle on only one of them releases nothing. After the second one toggles, the next item appears at `reqOut` on the second clock edge.
- R8: On a full pipeline with one more request waiting at the input, `ackOut` toggles on the edge numbered `STAGES`+1 after the release of R7. The vacancy moves back one stage per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Evaluation clock of the stage controllers |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | 1 | Producer request; every toggle offers one word |
| dataIn | input | WIDTH | Word bundled with `reqIn` |
| ackOut | output | 1 | Acknowledge to producer (done flag of first stage) |
| reqOut | output | 1 | Request to consumers (done flag of last stage) |
| dataOut | output | WIDTH | Word held by the last stage |
| ackInA | input | 1 | Acknowledge from consumer A |
| ackInB | input | 1 | Acknowledge from consumer B |

## Verification
All inputs change on the falling edge, and outputs are sampled on falling edges. Each sample therefore sees the result of a whole number of rising edges. The bench counts those edges against the figures in R5, R7 and R8. On an empty pipeline, it expects the acknowledge after one edge and the output request after `STAGES` edges. For the consumer merge, it expects nothing after a lone toggle of one acknowledge input. It expects the next word on exactly the second edge after the partner toggles, and the producer acknowledge on edge `STAGES`+1. Throughout the streaming phases, a behavioural queue is compared against `reqOut` and `dataOut` on every falling edge.

// File: rtl/tpPipePkg.sv
package tpPipePkg;
  // per-stage strobes from controller to datapath
  typedef struct packed {
    logic open;  // stage empty, latch transparent
    logic load;  // new item captured on this edge
  } stageStrobe_t;
endpackage

// File: rtl/tpCElement.sv
module tpCElement (
  input  logic clk,
  input  logic rstN,
  input  logic inA,
  input  logic inB,
  output logic outC
);
  always_ff @(posedge clk) begin
    if (!rstN) outC <= 1'b0;
    else if (inA == inB) outC <= inA;
  end

  // R7
  celem_agree_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outC != $past(outC)) |-> ($past(inA) == outC && $past(inB) == outC));
endmodule

// File: rtl/tpLatchCtrl.sv
module tpLatchCtrl
  import tpPipePkg::*;
#(
  parameter int STAGES = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqIn,
  input  logic         ackMerged,
  output logic         ackOut,
  output logic         reqOut,
  output stageStrobe_t strobe [STAGES]
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] doneQ;
  logic [STAGES-1:0] reqSrc;
  logic [STAGES-1:0] ackSrc;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_head
      assign reqSrc[s] = reqIn;
    end else begin : g_body
      assign reqSrc[s] = doneQ[s-1];
    end
    if (s == LAST) begin : g_tail
      assign ackSrc[s] = ackMerged;
    end else begin : g_mid
      assign ackSrc[s] = doneQ[s+1];
    end

    always_comb begin
      strobe[s].open = ~(doneQ[s] ^ ackSrc[s]);
      strobe[s].load = strobe[s].open & (reqSrc[s] ^ doneQ[s]);
    end

    always_ff @(posedge clk) begin
      if (!rstN) doneQ[s] <= 1'b0;
      else if (strobe[s].load) doneQ[s] <= reqSrc[s];
    end
  end

  assign ackOut = doneQ[0];
  assign reqOut = doneQ[LAST];

  // R2
  ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackOut != $past(ackOut)) |-> ($past(reqIn) != $past(ackOut)));

  // R2
  handshake_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackOut != $past(ackOut)) |=> $stable(ackOut));
endmodule

// File: rtl/tpLatchData.sv
module tpLatchData
  import tpPipePkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int STAGES = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [WIDTH-1:0]   dataIn,
  input  stageStrobe_t       strobe [STAGES],
  output logic [WIDTH-1:0]   dataOut
);
  logic [WIDTH-1:0] word [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_word
    logic [WIDTH-1:0] src;
    if (s == 0) begin : g_head
      assign src = dataIn;
    end else begin : g_body
      assign src = word[s-1];
    end
    always_ff @(posedge clk) begin
      if (!rstN) word[s] <= '0;
      else if (strobe[s].load) word[s] <= src;
    end
  end

  assign dataOut = word[STAGES-1];
endmodule

// File: rtl/tpLatchPipeline.sv
module tpLatchPipeline
  import tpPipePkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int STAGES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqIn,
  input  logic [WIDTH-1:0] dataIn,
  output logic             ackOut,
  output logic             reqOut,
  output logic [WIDTH-1:0] dataOut,
  input  logic             ackInA,
  input  logic             ackInB
);
  stageStrobe_t strobe [STAGES];
  logic ackMerged;

  tpCElement i_ackJoin (
    .clk  (clk),
    .rstN (rstN),
    .inA  (ackInA),
    .inB  (ackInB),
    .outC (ackMerged)
  );

  tpLatchCtrl #(.STAGES(STAGES)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqIn     (reqIn),
    .ackMerged (ackMerged),
    .ackOut    (ackOut),
    .reqOut    (reqOut),
    .strobe    (strobe)
  );

  tpLatchData #(.WIDTH(WIDTH), .STAGES(STAGES)) i_data (
    .clk     (clk),
    .rstN    (rstN),
    .dataIn  (dataIn),
    .strobe  (strobe),
    .dataOut (dataOut)
  );

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !rstN |=> (!ackOut && !reqOut && dataOut == '0));

  // R6
  pending_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqOut != ackMerged) |=> ($stable(reqOut) && $stable(dataOut)));
endmodule

// File: tb/test_tpLatchPipeline.sv
`timescale 1ns/1ps
module test_tpLatchPipeline;
  localparam int WIDTH  = 8;
  localparam int STAGES = 4;
  localparam int STREAM = 150;

  logic clk = 1'b0;
  logic rstN, reqIn, ackInA, ackInB;
  logic [WIDTH-1:0] dataIn;
  logic ackOut, reqOut;
  logic [WIDTH-1:0] dataOut;

  int checks = 0;
  int errors = 0;
  logic [WIDTH-1:0] expQ [$];
  logic seenReq = 1'b0;
  int nextVal = 1;
  bit timedOut = 0;

  tpLatchPipeline #(.WIDTH(WIDTH), .STAGES(STAGES)) i_tpLatchPipeline (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .dataIn(dataIn),
    .ackOut(ackOut), .reqOut(reqOut), .dataOut(dataOut),
    .ackInA(ackInA), .ackInB(ackInB)
  );

  initial forever #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // offer one item; returns edges until ackOut follows (-1 if never within limit)
  task automatic offer(input int limit, output int edges);
    logic [WIDTH-1:0] v;
    v = WIDTH'(nextVal);
    nextVal++;
    dataIn = v;
    reqIn = ~reqIn;
    expQ.push_back(v);
    edges = -1;
    for (int e = 1; e <= limit; e++) begin
      @(negedge clk);
      if (ackOut == reqIn) begin
        edges = e;
        break;
      end
    end
  endtask

  task automatic produce(input int count);
    int edges;
    for (int k = 0; k < count; k++) begin
      repeat ($urandom % 4) @(negedge clk);
      offer(200, edges);
      check(edges > 0, "R2 item acknowledged", edges, 1);
    end
  endtask

  // consumer with reference compare on every falling edge
  task automatic sinkRun(input int total);
    int got = 0;
    int wait_ = 0;
    while (got < total || reqOut != ackInA) begin
      @(negedge clk);
      if (reqOut != seenReq) begin
        check(expQ.size() > 0, "R4 no spurious output", expQ.size(), 1);
        if (expQ.size() > 0) begin
          check(dataOut == expQ[0], "R4 order and value", dataOut, expQ[0]);
          void'(expQ.pop_front());
        end
        seenReq = reqOut;
        got++;
        wait_ = $urandom % 3;
      end
      if (reqOut != ackInA) begin
        if (wait_ == 0) begin
          ackInA = reqOut;
          ackInB = reqOut;
        end else begin
          wait_--;
        end
      end
    end
  endtask

  initial begin
    rstN = 1'b0; reqIn = 1'b0; ackInA = 1'b0; ackInB = 1'b0; dataIn = '0;
    fork
      begin : body
        int edges;
        int firstAck;
        logic holdAck;
        repeat (3) @(negedge clk);
        check(ackOut == 1'b0 && reqOut == 1'b0, "R1 handshake zero in reset", {ackOut, reqOut}, 0);
        check(dataOut == '0, "R1 data zero in reset", dataOut, 0);
        rstN = 1'b1;
        @(negedge clk);
        check(ackOut == 1'b0 && reqOut == 1'b0, "R1 idle after reset", {ackOut, reqOut}, 0);

        // R5 latency on empty pipeline
        offer(5, edges);
        check(edges == 1, "R5 ackOut after one edge", edges, 1);
        edges = 1;
        while (reqOut == seenReq && edges < 50) begin
          @(negedge clk);
          edges++;
        end
        check(edges == STAGES, "R5 reqOut latency", edges, STAGES);
        check(dataOut == expQ[0], "R4 first word", dataOut, expQ[0]);
        void'(expQ.pop_front());
        seenReq = reqOut;
        sinkRun(0);

        // R3 capacity with consumers stalled
        firstAck = 0;
        for (int k = 0; k < STAGES + 1; k++) begin
          offer(4 * STAGES, edges);
          if (edges > 0) firstAck++;
          else break;
        end
        check(firstAck == STAGES, "R3 accepted while stalled", firstAck, STAGES);
        holdAck = ackOut;
        repeat (5) @(negedge clk);
        check(ackOut == holdAck && ackOut != reqIn, "R3 ackOut holds when full", ackOut, holdAck);
        check(reqOut != seenReq && dataOut == expQ[0], "R6 head word presented", dataOut, expQ[0]);
        void'(expQ.pop_front());
        seenReq = reqOut;

        // R7 one-sided acknowledge releases nothing
        ackInA = ~ackInA;
        repeat (6) @(negedge clk);
        check(reqOut == seenReq, "R7 lone ackInA ignored", reqOut, seenReq);
        check(ackOut == holdAck, "R7 input still stalled", ackOut, holdAck);

        // R7 / R8 partner toggles
        ackInB = ~ackInB;
        edges = -1;
        for (int e = 1; e <= 40; e++) begin
          @(negedge clk);
          if (e == 1) check(reqOut == seenReq, "R7 no release after one edge", reqOut, seenReq);
          if (e == 2) begin
            check(reqOut != seenReq, "R7 release after two edges", reqOut, ~seenReq);
            check(dataOut == expQ[0], "R4 word after release", dataOut, expQ[0]);
            void'(expQ.pop_front());
            seenReq = reqOut;
          end
          if (edges < 0 && ackOut == reqIn) edges = e;
          if (e >= 2 && edges > 0) break;
        end
        check(edges == STAGES + 1, "R8 vacancy reaches input", edges, STAGES + 1);

        // drain then stream with random gaps (both reqIn polarities)
        sinkRun(expQ.size());
        fork
          produce(STREAM);
          sinkRun(STREAM);
        join
        check(expQ.size() == 0, "R4 every word delivered once", expQ.size(), 0);
        repeat (4) @(negedge clk);
        check(reqOut == seenReq, "R4 no extra output", reqOut, seenReq);
      end
      begin
        #(100000 * 5);
        timedOut = 1;
      end
    join_any
    disable fork;
    if (timedOut) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule